// File: doc/BRIEF.md
# Configuration transaction control engine

This block gives software a small three-register window for launching one-shot configuration transactions toward devices on a board configuration network. Software places an operand in the operand register, then writes a command word whose top bit starts the transaction. The command word is split into direction, controller select, function, site, position and device fields. The engine decides in the same cycle whether the addressed target and function are supported. It then records completion, and an error when it fails, in a two-bit status register.

The only supported actions are two write functions aimed at the main board's device 0: a power-off request and a restart request. Each leaves the block as a single-cycle pulse. Every read transaction is unsupported, so it reports an error and leaves the operand register as it was. The window is live only when the board-variant input carries the matching variant code. For any other code the three offsets read as zero and ignore writes.

Top module: `cfgx_engine`

## Requirements
- R1: After a synchronous reset the operand, command and status registers read as zero, the read data output is zero and both request outputs are low.
- R2: A write to offset 0xA0 stores all 32 bits of the operand register, and a read of 0xA0 returns them.
- R3: A write to the command register at offset 0xA4 stores the word with bits 31, 19 and 18 forced to zero, so those bits always read back as zero.
- R4: A command write with bit 31 set makes the status register at 0xA8 show bit 0 (complete) = 1 from the cycle after the write. A command write with bit 31 clear leaves status unchanged.
- R5: A started transaction fails, and status reads 3, when the controller select field [29:26] is nonzero, the position field [15:12] is nonzero, or the site field [17:16] is 2 or 3.
- R6: A started write (bit 30 = 1) with function field [25:20] = 8, site 0, device field [11:0] = 0 and an accepted target sets status to 1. It raises the power-off request output for exactly the one cycle after the command write.
- R7: The same write with function 9 sets status to 1 and raises the restart request output for exactly one cycle.
- R8: Any other started write fails with status 3 and raises no request. This covers other functions, and functions 8 or 9 aimed at site 1 or at a nonzero device.
- R9: A started read (bit 30 = 0) always fails with status 3 and leaves the operand register unchanged.
- R10: A direct write to the status register stores only bits [1:0] of the written value.
- R11: When the board-variant input differs from 0x190, reads of the three offsets return zero, writes to them change nothing and no request is raised.
- R12: Read data is registered: it appears on the cycle after the read strobe. Offsets outside the three registers, and cycles without a read strobe, give zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| board_variant | input | 12 | Board variant code; the window is live only at 0x190 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| poweroff_req | output | 1 | Single-cycle power-off request |
| restart_req | output | 1 | Single-cycle restart request |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle, and that the board-variant code changes only between accesses. The request-cause checks look one cycle back at the strobe, address and variant, so they depend on both. The stimulus issues one access per task call and drops its strobe before the next one. It changes the variant only between those calls. The random command words draw each field mostly from the accepted values, with occasional out-of-range picks, so that both the success and the failure paths are reached often.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam int WORD_W  = 32;
  localparam int CSEL_W  = 4;
  localparam int FUNC_W  = 6;
  localparam int SITE_W  = 2;
  localparam int POS_W   = 4;
  localparam int DEV_W   = 12;
  localparam int STAT_W  = 2;

  localparam int START_BIT = 31;
  localparam int DIR_BIT   = 30;
  localparam int CSEL_LSB  = 26;
  localparam int FUNC_LSB  = 20;
  localparam int SITE_LSB  = 16;
  localparam int POS_LSB   = 12;
  localparam int DEV_LSB   = 0;

  localparam logic [WORD_W-1:0] CMD_KEEP_MASK = 32'h7FF3_FFFF;

  typedef enum logic [FUNC_W-1:0] {
    FN_POWEROFF = 6'd8,
    FN_RESTART  = 6'd9
  } cfg_func_e;

  typedef struct packed {
    logic              start;
    logic              is_write;
    logic [CSEL_W-1:0] csel;
    logic [FUNC_W-1:0] func;
    logic [SITE_W-1:0] site;
    logic [POS_W-1:0]  pos;
    logic [DEV_W-1:0]  dev;
  } cmd_fields_t;

  typedef struct packed {
    logic ok;
    logic poweroff;
    logic restart;
  } cmd_verdict_t;
endpackage

// File: rtl/cfgx_field_split.sv
module cfgx_field_split
  import cfgx_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output cmd_fields_t       fields
);
  always_comb begin
    fields.start    = word[START_BIT];
    fields.is_write = word[DIR_BIT];
    fields.csel     = word[CSEL_LSB +: CSEL_W];
    fields.func     = word[FUNC_LSB +: FUNC_W];
    fields.site     = word[SITE_LSB +: SITE_W];
    fields.pos      = word[POS_LSB +: POS_W];
    fields.dev      = word[DEV_LSB +: DEV_W];
  end
endmodule

// File: rtl/cfgx_action.sv
module cfgx_action
  import cfgx_pkg::*;
#(
  parameter int MAX_SITE = 1
) (
  input  cmd_fields_t  fields,
  output cmd_verdict_t verdict
);
  logic target_ok;
  logic main_dev0;

  always_comb begin
    target_ok = (fields.csel == '0) && (fields.pos == '0) &&
                (int'(fields.site) <= MAX_SITE);
    main_dev0 = (fields.site == '0) && (fields.dev == '0);
    verdict   = '0;
    if (target_ok && fields.is_write && main_dev0) begin
      unique case (fields.func)
        FN_POWEROFF: begin verdict.ok = 1'b1; verdict.poweroff = 1'b1; end
        FN_RESTART:  begin verdict.ok = 1'b1; verdict.restart  = 1'b1; end
        default:     verdict = '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgx_regs.sv
module cfgx_regs
  import cfgx_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFS_DATA = 12'hA0,
  parameter logic [ADDR_W-1:0] OFS_CMD  = 12'hA4,
  parameter logic [ADDR_W-1:0] OFS_STAT = 12'hA8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              live,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  cmd_verdict_t      verdict,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              poweroff_req,
  output logic              restart_req
);
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] cmd_q;
  logic [STAT_W-1:0] stat_q;

  logic wr_data, wr_cmd, wr_stat, launch;

  always_comb begin
    wr_data = live && bus_wr && (bus_addr == OFS_DATA);
    wr_cmd  = live && bus_wr && (bus_addr == OFS_CMD);
    wr_stat = live && bus_wr && (bus_addr == OFS_STAT);
    launch  = wr_cmd && bus_wdata[START_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      cmd_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_data) data_q <= bus_wdata;
      if (wr_cmd)  cmd_q  <= bus_wdata & CMD_KEEP_MASK;
      if (launch)
        stat_q <= {~verdict.ok, 1'b1};
      else if (wr_stat)
        stat_q <= bus_wdata[STAT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poweroff_req <= 1'b0;
      restart_req  <= 1'b0;
    end else begin
      poweroff_req <= launch && verdict.poweroff;
      restart_req  <= launch && verdict.restart;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (live && bus_rd) begin
      if (bus_addr == OFS_DATA)      bus_rdata <= data_q;
      else if (bus_addr == OFS_CMD)  bus_rdata <= cmd_q;
      else if (bus_addr == OFS_STAT) bus_rdata <= {{(WORD_W-STAT_W){1'b0}}, stat_q};
      else                           bus_rdata <= '0;
    end else begin
      bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
  import cfgx_pkg::*;
#(
  parameter int                 ADDR_W      = 12,
  parameter int                 VARIANT_W   = 12,
  parameter logic [VARIANT_W-1:0] VARIANT_ON = 12'h190,
  parameter int                 MAX_SITE    = 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [VARIANT_W-1:0] board_variant,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 poweroff_req,
  output logic                 restart_req
);
  cmd_fields_t  fields;
  cmd_verdict_t verdict;
  logic         live;

  assign live = (board_variant == VARIANT_ON);

  cfgx_field_split u_split (
    .word   (bus_wdata),
    .fields (fields)
  );

  cfgx_action #(.MAX_SITE(MAX_SITE)) u_action (
    .fields  (fields),
    .verdict (verdict)
  );

  cfgx_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst          (rst),
    .live         (live),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .verdict      (verdict),
    .bus_rdata    (bus_rdata),
    .poweroff_req (poweroff_req),
    .restart_req  (restart_req)
  );
endmodule

// File: rtl/cfgx_engine_chk.sv
module cfgx_engine_chk #(
  parameter int ADDR_W    = 12,
  parameter int VARIANT_W = 12,
  parameter logic [VARIANT_W-1:0] VARIANT_ON = 12'h190
) (
  input logic                 clk,
  input logic                 rst,
  input logic [VARIANT_W-1:0] board_variant,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic                 poweroff_req,
  input logic                 restart_req
);
  AST_POWEROFF_PULSE: assert property (@(posedge clk) disable iff (rst)
    poweroff_req |=> !poweroff_req); // R6
  AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (rst)
    restart_req |=> !restart_req); // R7
  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (rst)
    !(poweroff_req && restart_req)); // R8
  AST_POWEROFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    poweroff_req |-> $past(bus_wr && bus_addr == 12'hA4 && bus_wdata[31] &&
                           bus_wdata[30] && bus_wdata[25:20] == 6'd8 &&
                           board_variant == VARIANT_ON)); // R6
  AST_RESTART_CAUSE: assert property (@(posedge clk) disable iff (rst)
    restart_req |-> $past(bus_wr && bus_addr == 12'hA4 && bus_wdata[31] &&
                          bus_wdata[30] && bus_wdata[25:20] == 6'd9 &&
                          board_variant == VARIANT_ON)); // R7
  AST_OFF_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && board_variant != VARIANT_ON) |=> bus_rdata == 32'd0); // R11
  AST_IDLE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> bus_rdata == 32'd0); // R12
  AST_CMD_MASKED: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 12'hA4) |=> bus_rdata[31] == 1'b0 &&
                                       bus_rdata[19:18] == 2'b00); // R3
  AST_STAT_NARROW: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 12'hA8) |=> bus_rdata[31:2] == 30'd0); // R10
endmodule

bind cfgx_engine cfgx_engine_chk #(
  .ADDR_W(ADDR_W), .VARIANT_W(VARIANT_W), .VARIANT_ON(VARIANT_ON)
) u_chk (
  .clk(clk), .rst(rst), .board_variant(board_variant), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .poweroff_req(poweroff_req), .restart_req(restart_req)
);

// File: tb/sim_cfgx_engine.sv
module sim_cfgx_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] board_variant = 12'h190;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        poweroff_req, restart_req;

  int total = 0, bad = 0;
  logic [31:0] m_data = 0, m_cmd = 0;
  logic [1:0]  m_stat = 0;

  always #5 clk = ~clk;

  cfgx_engine u0 (
    .clk(clk), .rst(rst), .board_variant(board_variant), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .poweroff_req(poweroff_req), .restart_req(restart_req)
  );

  function automatic logic [1:0] exp_req(input logic [31:0] w);
    logic ok;
    ok = w[31] && w[30] && w[29:26] == 0 && w[15:12] == 0 &&
         w[17:16] == 0 && w[11:0] == 0 && (w[25:20] == 8 || w[25:20] == 9);
    if (!ok) return 2'b00;
    return (w[25:20] == 8) ? 2'b01 : 2'b10;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] w, input string req);
    logic [1:0] er;
    logic live;
    live = (board_variant == 12'h190);
    er = live && a == 12'hA4 ? exp_req(w) : 2'b00;
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = w;
    @(negedge clk);
    bus_wr = 1'b0;
    check(req, {30'd0, restart_req, poweroff_req}, {30'd0, er[1], er[0]});
    if (live) begin
      if (a == 12'hA0) m_data = w;
      if (a == 12'hA4) begin
        m_cmd = w & 32'h7FF3FFFF;
        if (w[31]) m_stat = (er != 0) ? 2'd1 : 2'd3;
      end
      if (a == 12'hA8) m_stat = w[1:0];
    end
    @(negedge clk);
    check(req, {30'd0, restart_req, poweroff_req}, 32'd0);
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic read_all(input string req);
    do_read(12'hA0, m_data, req);
    do_read(12'hA4, m_cmd, req);
    do_read(12'hA8, {30'd0, m_stat}, req);
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    check("R1", {30'd0, restart_req, poweroff_req}, 32'd0);
    check("R1", bus_rdata, 32'd0);
    rst = 1'b0;
    read_all("R1");

    do_write(12'hA0, 32'hDEAD_BEEF, "R2");
    do_read(12'hA0, 32'hDEAD_BEEF, "R2");
    do_write(12'hA4, 32'h7FFF_FFFF, "R3");
    do_read(12'hA4, 32'h7FF3_FFFF, "R3");
    do_read(12'hA8, 32'd0, "R4");
    do_write(12'hA4, 32'hC080_0000, "R6");
    do_read(12'hA8, 32'd1, "R6");
    do_read(12'hA4, 32'h4080_0000, "R3");
    do_write(12'hA4, 32'hC090_0000, "R7");
    do_read(12'hA8, 32'd1, "R7");
    do_write(12'hA8, 32'hFFFF_FFF2, "R10");
    do_read(12'hA8, 32'd2, "R10");
    do_write(12'hA4, 32'hC490_0000, "R5");
    do_read(12'hA8, 32'd3, "R5");
    do_write(12'hA4, 32'hC082_0000, "R5");
    do_read(12'hA8, 32'd3, "R5");
    do_write(12'hA4, 32'hC080_1000, "R5");
    do_read(12'hA8, 32'd3, "R5");
    do_write(12'hA4, 32'hC081_0000, "R8");
    do_read(12'hA8, 32'd3, "R8");
    do_write(12'hA4, 32'hC080_0001, "R8");
    do_write(12'hA4, 32'hC0A0_0000, "R8");
    do_read(12'hA8, 32'd3, "R8");
    do_write(12'hA8, 32'd0, "R10");
    do_write(12'hA4, 32'h4090_0000, "R4");
    do_read(12'hA8, 32'd0, "R4");
    do_write(12'hA4, 32'h8080_0000, "R9");
    do_read(12'hA8, 32'd3, "R9");
    do_read(12'hA0, 32'hDEAD_BEEF, "R9");
    do_read(12'h000, 32'd0, "R12");

    board_variant = 12'h178;
    do_read(12'hA0, 32'd0, "R11");
    do_write(12'hA0, 32'h1234_5678, "R11");
    do_write(12'hA4, 32'hC080_0000, "R11");
    board_variant = 12'h190;
    read_all("R11");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      logic [11:0] a;
      int k;
      k = $urandom_range(0, 9);
      a = (k < 2) ? 12'hA0 : (k < 8) ? 12'hA4 : 12'hA8;
      w = $urandom;
      if (a == 12'hA4) begin
        w[31] = ($urandom_range(0, 4) != 0);
        if ($urandom_range(0, 4) != 0) w[29:26] = 0;
        if ($urandom_range(0, 4) != 0) w[15:12] = 0;
        if ($urandom_range(0, 3) != 0) w[17:16] = 2'($urandom_range(0, 1));
        if ($urandom_range(0, 3) != 0) w[11:0] = 0;
        if ($urandom_range(0, 2) != 0) w[25:20] = 6'($urandom_range(8, 9));
      end
      board_variant = ($urandom_range(0, 9) == 0) ? 12'h182 : 12'h190;
      do_write(a, w, "R8");
      board_variant = 12'h190;
      if (i % 4 == 0) read_all("R4");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule